// File: doc/BRIEF.md
# Two-Level Dynamic-Priority Request Arbiter

This block settles contention among four requesters for one shared resource. Each requester drives a two-wire code that carries both the fact that it wants the resource and a one-bit urgency level. The arbiter samples all four codes together and judges them in two levels. The first level has two pair judges that work side by side: one covers inputs 0 and 1, the other covers inputs 2 and 3. When only one pair has a candidate, that candidate is granted at once. When both pairs have a candidate, a final judge compares the two candidates' urgency levels and grants one of them.

The winner is acknowledged on its own acknowledge line. In the same cycle, the arbiter raises a single-rail request towards the shared resource and holds it until that resource answers, following a four-phase return-to-zero handshake. A status output tells whether the last grant came from the early path or from the final judge. A sticky flag records any requester that drives both wires high at once.

The design is a clocked model of a clock-less arbiter. The sequencing is carried by a small state machine, and a synchronous active-high reset clears it.

Top module: `darb_top`

## Requirements
- R1: Input i uses bit i of `req_p1_i` and bit i of `req_p0_i`. The value (1,0) means a request with urgency 1, the higher level. The value (0,1) means a request with urgency 0. The value (0,0) means idle. Acknowledge i is bit i of `ack_o`.
- R2: Among the legal active requests, the one with the highest urgency is granted. When urgencies are equal, the higher input index wins. This rule holds both inside a pair and between the two pair candidates.
- R3: A round can start only in the idle state. It starts on the first rising edge at which some input holds a legal request, and all four codes are sampled on that edge. If only one pair (inputs 0-1 or inputs 2-3) has a candidate, the grant shows on the second rising edge counted from that sampling edge, and `late_grant_o` reads 0.
- R4: If both pairs have a candidate, the grant shows on the third rising edge and `late_grant_o` reads 1. The upper-pair candidate wins when its urgency is greater than or equal to that of the lower-pair candidate.
- R5: At most one acknowledge is high at any time. `res_req_o` rises on the same edge as the winner's acknowledge.
- R6: `res_req_o` stays high until `res_ack_i` is seen high. It falls on the following rising edge.
- R7: The winner's acknowledge stays high while either of its wires is high. It falls on the first rising edge at which both of its wires are seen low.
- R8: No new round starts until all of these are low: every acknowledge, `res_req_o` and `res_ack_i`. A request that arrives while `res_ack_i` is still high is served only after `res_ack_i` falls, and its grant shows three edges after that fall.
- R9: An input with both wires high is treated as idle for arbitration. On the next rising edge, `bad_code_o` goes high and stays high until reset.
- R10: While `rst` is high, all acknowledges, `res_req_o`, `late_grant_o` and `bad_code_o` are cleared at each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_p1_i | input | 4 | Per-input wire meaning "request, urgency 1" |
| req_p0_i | input | 4 | Per-input wire meaning "request, urgency 0" |
| ack_o | output | 4 | Per-input acknowledge, one-hot or zero |
| res_req_o | output | 1 | Request to the shared resource |
| res_ack_i | input | 1 | Acknowledge from the shared resource |
| late_grant_o | output | 1 | 1 when the last grant needed the final judge |
| bad_code_o | output | 1 | Sticky flag for an input with both wires high |

## Verification
A wrong pair code or a wrong final-judge result shows up as the wrong bit of `ack_o` on the grant edge. Because the early path and the final path differ by exactly one edge, a corrupted solo-or-both decision also shows up as a grant one cycle early or late, and as a wrong value on `late_grant_o` in that same cycle. A state machine that leaves its hold state too early or too late shows up in two ways: an acknowledge or `res_req_o` that drops before its release condition, or a second request that is granted while `res_ack_i` is still high. Both are visible within one cycle of the release event.

// File: rtl/darb_pkg.sv
package darb_pkg;

    localparam int N_IN   = 4;
    localparam int N_PAIR = N_IN / 2;
    localparam int IDX_W  = $clog2(N_IN);

    // Result code of one pair judge
    typedef enum logic [1:0] {
        PC_NONE = 2'd0,
        PC_LOW  = 2'd1,
        PC_HIGH = 2'd2
    } pcode_e;

    typedef struct packed {
        pcode_e code;
        logic   prio;
    } pres_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_CMP,
        ST_HOLD
    } st_e;

    function automatic logic [N_IN-1:0] to_onehot(input logic [IDX_W-1:0] idx);
        return N_IN'(1) << idx;
    endfunction

endpackage

// File: rtl/darb_pair.sv
module darb_pair
    import darb_pkg::*;
(
    input  logic [1:0] vld_i,
    input  logic [1:0] prio_i,
    output pres_t      res_o
);

    always_comb begin
        res_o = '{code: PC_NONE, prio: 1'b0};
        unique case (vld_i)
            2'b01: res_o = '{code: PC_LOW,  prio: prio_i[0]};
            2'b10: res_o = '{code: PC_HIGH, prio: prio_i[1]};
            2'b11: begin
                // equal urgency goes to the higher index
                if (prio_i[1] >= prio_i[0])
                    res_o = '{code: PC_HIGH, prio: prio_i[1]};
                else
                    res_o = '{code: PC_LOW,  prio: prio_i[0]};
            end
            default: res_o = '{code: PC_NONE, prio: 1'b0};
        endcase
    end

endmodule

// File: rtl/darb_final.sv
module darb_final
    import darb_pkg::*;
(
    input  pres_t             lo_i,
    input  pres_t             hi_i,
    output logic              solo_o,
    output logic [IDX_W-1:0]  solo_idx_o,
    output logic [IDX_W-1:0]  lo_idx_o,
    output logic [IDX_W-1:0]  hi_idx_o,
    output logic              upper_wins_o
);

    logic lo_act, hi_act;

    assign lo_act       = (lo_i.code != PC_NONE);
    assign hi_act       = (hi_i.code != PC_NONE);
    assign lo_idx_o     = {1'b0, lo_i.code == PC_HIGH};
    assign hi_idx_o     = {1'b1, hi_i.code == PC_HIGH};
    assign solo_o       = lo_act ^ hi_act;
    assign solo_idx_o   = hi_act ? hi_idx_o : lo_idx_o;
    assign upper_wins_o = (hi_i.prio >= lo_i.prio);

endmodule

// File: rtl/darb_top.sv
module darb_top
    import darb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] req_p1_i,
    input  logic [N_IN-1:0] req_p0_i,
    output logic [N_IN-1:0] ack_o,
    output logic            res_req_o,
    input  logic            res_ack_i,
    output logic            late_grant_o,
    output logic            bad_code_o
);

    st_e             state_q;
    logic [N_IN-1:0] legal;
    logic [N_IN-1:0] ack_q;
    logic            res_req_q, late_q, err_q, cmp_q;
    pres_t           pair_live [N_PAIR];
    pres_t           pair_q    [N_PAIR];

    logic             solo, upper_wins;
    logic [IDX_W-1:0] solo_idx, lo_idx, hi_idx;

    // exactly one wire high is a legal request; both high is dropped
    assign legal = req_p1_i ^ req_p0_i;

    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        darb_pair u_pair (
            .vld_i  (legal[2*g+1 -: 2]),
            .prio_i (req_p1_i[2*g+1 -: 2]),
            .res_o  (pair_live[g])
        );
    end

    darb_final u_final (
        .lo_i         (pair_q[0]),
        .hi_i         (pair_q[1]),
        .solo_o       (solo),
        .solo_idx_o   (solo_idx),
        .lo_idx_o     (lo_idx),
        .hi_idx_o     (hi_idx),
        .upper_wins_o (upper_wins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ack_q     <= '0;
            res_req_q <= 1'b0;
            late_q    <= 1'b0;
            err_q     <= 1'b0;
            cmp_q     <= 1'b0;
            for (int k = 0; k < N_PAIR; k++) pair_q[k] <= '0;
        end else begin
            if (|(req_p1_i & req_p0_i)) err_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (|legal) begin
                        for (int k = 0; k < N_PAIR; k++) pair_q[k] <= pair_live[k];
                        state_q <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (solo) begin
                        ack_q     <= to_onehot(solo_idx);
                        res_req_q <= 1'b1;
                        late_q    <= 1'b0;
                        state_q   <= ST_HOLD;
                    end else begin
                        cmp_q   <= upper_wins;
                        state_q <= ST_CMP;
                    end
                end
                ST_CMP: begin
                    ack_q     <= to_onehot(cmp_q ? hi_idx : lo_idx);
                    res_req_q <= 1'b1;
                    late_q    <= 1'b1;
                    state_q   <= ST_HOLD;
                end
                ST_HOLD: begin
                    ack_q <= ack_q & (req_p1_i | req_p0_i);
                    if (res_req_q && res_ack_i) res_req_q <= 1'b0;
                    if ((ack_q == '0) && !res_req_q && !res_ack_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ack_o        = ack_q;
    assign res_req_o    = res_req_q;
    assign late_grant_o = late_q;
    assign bad_code_o   = err_q;

    // ---------------- assertions ----------------
    assert_codes_live_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECIDE) |-> (pair_q[0].code != PC_NONE || pair_q[1].code != PC_NONE));

    assert_one_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_q));

    assert_req_with_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(|ack_q) |-> res_req_q);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (res_req_q && !res_ack_i) |=> res_req_q);

    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (|(ack_q & (req_p1_i | req_p0_i))) |=> (ack_q == $past(ack_q)));

    assert_no_start_R8: assert property (@(posedge clk) disable iff (rst)
        (res_ack_i && (ack_q == '0)) |=> (ack_q == '0));

    assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
        (|(req_p1_i & req_p0_i)) |=> err_q);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: tb/tb_darb_top.sv
module tb_darb_top;

    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] p1 = '0, p0 = '0;
    logic [3:0] ack;
    logic       res_req, res_ack = 1'b0, late, bad;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    darb_top dut (
        .clk          (clk),
        .rst          (rst),
        .req_p1_i     (p1),
        .req_p0_i     (p0),
        .ack_o        (ack),
        .res_req_o    (res_req),
        .res_ack_i    (res_ack),
        .late_grant_o (late),
        .bad_code_o   (bad)
    );

    // {p1[3:0], p0[3:0], expected ack[3:0], expected late flag}
    localparam logic [12:0] VEC [12] = '{
        {4'b0000, 4'b0001, 4'b0001, 1'b0},
        {4'b1000, 4'b0000, 4'b1000, 1'b0},
        {4'b0001, 4'b0010, 4'b0001, 1'b0},
        {4'b0000, 4'b0011, 4'b0010, 1'b0},
        {4'b0100, 4'b1000, 4'b0100, 1'b0},
        {4'b0001, 4'b0100, 4'b0001, 1'b1},
        {4'b0000, 4'b1010, 4'b1000, 1'b1},
        {4'b1111, 4'b0000, 4'b1000, 1'b1},
        {4'b0000, 4'b1111, 4'b1000, 1'b1},
        {4'b0001, 4'b1110, 4'b0001, 1'b1},
        {4'b0110, 4'b0000, 4'b0100, 1'b1},
        {4'b1000, 4'b0001, 4'b1000, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_grant(input int limit, output int n);
        n = 0;
        while (n < limit && ack == 4'b0000) begin
            step(1);
            n++;
        end
    endtask

    // finish the handshake and release the inputs, checking R6 and R7
    task automatic release_round(input logic [3:0] won);
        step(2);
        chk("R6 request held without answer", res_req, 1'b1);
        chk("R7 ack held while wires high", ack, won);
        res_ack = 1'b1;
        step(1);
        chk("R6 request falls after answer", res_req, 1'b0);
        res_ack = 1'b0;
        step(1);
        chk("R7 ack held after handshake", ack, won);
        p1 = '0; p0 = '0;
        step(1);
        chk("R7 ack falls when wires low", ack, 4'b0000);
        step(2);
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        step(2);
        chk("R10 ack after reset", ack, 4'b0000);
        chk("R10 res_req after reset", res_req, 1'b0);
        chk("R10 late flag after reset", late, 1'b0);
        chk("R10 bad flag after reset", bad, 1'b0);
        rst = 1'b0;
        step(1);

        // table walk: R1 encoding, R2 ordering, R3/R4 latency and stage
        for (int v = 0; v < 12; v++) begin
            p1 = VEC[v][12:9];
            p0 = VEC[v][8:5];
            wait_grant(8, n);
            chk($sformatf("R2 winner vec%0d", v), ack, VEC[v][4:1]);
            chk($sformatf("R3 R4 latency vec%0d", v), n, 2 + VEC[v][0]);
            chk($sformatf("R4 late flag vec%0d", v), late, VEC[v][0]);
            chk($sformatf("R5 res_req with ack vec%0d", v), res_req, 1'b1);
            release_round(VEC[v][4:1]);
        end
        chk("R9 no bad flag on legal codes", bad, 1'b0);

        // R8: a new request waits while the resource answer is still high
        p0 = 4'b0001;
        wait_grant(8, n);
        chk("R8 first grant", ack, 4'b0001);
        res_ack = 1'b1;
        step(1);
        chk("R6 request falls", res_req, 1'b0);
        p0 = 4'b0000;
        step(1);
        chk("R7 ack falls", ack, 4'b0000);
        p0 = 4'b0010;
        step(4);
        chk("R8 no grant while answer high", ack, 4'b0000);
        res_ack = 1'b0;
        wait_grant(8, n);
        chk("R8 grant after answer falls", ack, 4'b0010);
        chk("R8 latency after answer falls", n, 3);
        release_round(4'b0010);

        // R9: both wires high on input 3, legal low urgency on input 0
        p1 = 4'b1000; p0 = 4'b1001;
        wait_grant(8, n);
        chk("R9 illegal input ignored", ack, 4'b0001);
        chk("R9 early path", late, 1'b0);
        chk("R9 flag set", bad, 1'b1);
        release_round(4'b0001);

        // R9: an illegal code alone starts nothing
        p1 = 4'b0100; p0 = 4'b0100;
        step(5);
        chk("R9 no grant on illegal only", ack, 4'b0000);
        chk("R9 no resource request", res_req, 1'b0);
        p1 = '0; p0 = '0;
        step(2);
        chk("R9 flag sticky", bad, 1'b1);

        // R10: reset clears sticky flag and state
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        step(1);
        chk("R10 bad cleared by reset", bad, 1'b0);
        chk("R10 late cleared by reset", late, 1'b0);
        p1 = 4'b0010;
        wait_grant(8, n);
        chk("R10 arbitration after reset", ack, 4'b0010);
        release_round(4'b0010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule